// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block takes a set of interrupt request lines and picks the one with the highest priority. It then decides whether the CPU should take that interrupt by comparing its level with the CPU's current 4-bit mask. There is one non-maskable source, two debug-side sources with a fixed level (a user break and a debug-interface request), and `N_SRC` external or peripheral requests. Each of the `N_SRC` requests has a 4-bit priority that software sets through a simple write port.

The block uses 17 levels, from 0 to 16. The non-maskable source sits at level 16, above every level that can be programmed. When the non-maskable source is taken, the mask value handed back to the CPU is 15. When a request wins, the block raises a registered interrupt line together with the winner's vector number and the new mask value. These three outputs stay frozen until the CPU gives a one-cycle acknowledge. The next arbitration round starts after that.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `irq_o` is 0. All programmable priorities reset to level 0, so requests from the programmable sources alone can never raise `irq_o` after reset.
- R2: `nmi_i` has level 16 and is accepted for any value of `cpu_mask_i`. Its vector is 11 and its new mask is 15.
- R3: `ubrk_i` and `dbg_i` each have fixed level 15 and are accepted only when `cpu_mask_i` is below 15. Their vectors are 12 and 13, and their new mask is 15.
- R4: A cycle with `wr_en_i` = 1 sets the priority of programmable source `wr_idx_i` to `wr_lvl_i` (0 to 15). The new value applies from the next cycle.
- R5: A maskable request is accepted only when its level is strictly greater than `cpu_mask_i`. A source at level 0 is never accepted.
- R6: Among the eligible pending requests, the one with the highest level wins.
- R7: When levels are equal, the lower slot index wins. The slots are ordered non-maskable (0), user break (1), debug (2), then programmable source k at slot 3+k.
- R8: `new_mask_o` equals the level of the accepted request, except for the non-maskable source, which gives 15.
- R9: `vec_o` gives 11, 12 or 13 for the three fixed sources and 64+k for programmable source k.
- R10: Inputs are sampled at a clock edge, and an accepted request shows on `irq_o`, `vec_o` and `new_mask_o` after that edge. While `irq_o` = 1 and `ack_i` = 0, all three outputs stay unchanged whatever the inputs do. An edge with `ack_i` = 1 clears `irq_o`. When nothing is eligible, `irq_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_i | input | 1 | Non-maskable request, level 16 |
| ubrk_i | input | 1 | User break request, level 15 |
| dbg_i | input | 1 | Debug-interface request, level 15 |
| req_i | input | N_SRC | Programmable-level requests, one bit per source |
| cpu_mask_i | input | 4 | Current CPU mask level |
| wr_en_i | input | 1 | Priority register write strobe |
| wr_idx_i | input | $clog2(N_SRC) | Source index to write |
| wr_lvl_i | input | 4 | Priority level to write |
| ack_i | input | 1 | One-cycle acknowledge from the CPU |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | VEC_W | Vector number of the accepted source |
| new_mask_o | output | 4 | Mask value for the CPU to load |

## Verification
The assertions check the cycle-level rules on every cycle. They check the output freeze while a request is not yet acknowledged, the drop after acknowledge, and that no request rises when nothing is pending. They also check that a non-maskable input always produces the vector-11 request with mask 15, and that any other newly raised request carries a mask above the one that was sampled. Which source wins among several pending ones cannot be seen from a single property. That covers level ordering, index tie-breaks, the exact vector numbers, the effect of programmed priorities and the level-0 exclusion. Only the bench's directed and random scenarios show these, checked against its own model.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  // Fixed arbitration slots ahead of the programmable sources
  typedef enum int {
    SLOT_NMI  = 0,
    SLOT_UBRK = 1,
    SLOT_DBG  = 2
  } fixed_slot_e;

  localparam int FIXED_SLOTS = 3;

  // Level of the non-maskable slot and of the debug-side slots for a given
  // programmable priority width
  function automatic int top_level(input int prio_w);
    return 1 << prio_w;
  endfunction

  function automatic int max_settable(input int prio_w);
    return (1 << prio_w) - 1;
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
`timescale 1ns/1ps
module irq_prio_regs #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 4,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [PRIO_W-1:0]             wr_lvl_i,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;

  // All entries are read in parallel, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (wr_en_i) begin
      prio_q[wr_idx_i] <= wr_lvl_i;
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int PRIO_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int NMI_VEC  = 11,
  parameter int UBRK_VEC = 12,
  parameter int DBG_VEC  = 13
) (
  input  logic                          nmi_i,
  input  logic                          ubrk_i,
  input  logic                          dbg_i,
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0]  prio_i,
  input  logic [PRIO_W-1:0]             cpu_mask_i,
  output logic                          hit_o,
  output logic [VEC_W-1:0]              vec_o,
  output logic [PRIO_W-1:0]             mask_o
);
  localparam int NT = N_SRC + FIXED_SLOTS;
  localparam int TW = $clog2(NT);
  localparam int LW = PRIO_W + 1;
  localparam logic [LW-1:0] LVL_TOP = LW'(top_level(PRIO_W));
  localparam logic [LW-1:0] LVL_MAX = LW'(max_settable(PRIO_W));

  logic [LW-1:0] lvl  [NT];
  logic [NT-1:0] pend;

  assign lvl[SLOT_NMI]   = LVL_TOP;
  assign lvl[SLOT_UBRK]  = LVL_MAX;
  assign lvl[SLOT_DBG]   = LVL_MAX;
  assign pend[SLOT_NMI]  = nmi_i;
  assign pend[SLOT_UBRK] = ubrk_i;
  assign pend[SLOT_DBG]  = dbg_i;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign lvl[k+FIXED_SLOTS]  = {1'b0, prio_i[k]};
    assign pend[k+FIXED_SLOTS] = req_i[k];
  end

  logic          found;
  logic [LW-1:0] best_lvl;
  logic [TW-1:0] best_idx;

  // Ascending scan with strict compare: equal levels keep the lower slot
  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NT; i++) begin
      if (pend[i] && (i == SLOT_NMI || lvl[i] > {1'b0, cpu_mask_i})) begin
        if (!found || lvl[i] > best_lvl) begin
          found    = 1'b1;
          best_lvl = lvl[i];
          best_idx = TW'(i);
        end
      end
    end
  end

  always_comb begin
    case (best_idx)
      TW'(SLOT_NMI):  vec_o = VEC_W'(NMI_VEC);
      TW'(SLOT_UBRK): vec_o = VEC_W'(UBRK_VEC);
      TW'(SLOT_DBG):  vec_o = VEC_W'(DBG_VEC);
      default:        vec_o = VEC_W'(VEC_BASE) + VEC_W'(best_idx) - VEC_W'(FIXED_SLOTS);
    endcase
  end

  assign hit_o  = found;
  assign mask_o = (best_lvl > LVL_MAX) ? PRIO_W'(LVL_MAX) : best_lvl[PRIO_W-1:0];
endmodule

// File: rtl/irq_hold_stage.sv
`timescale 1ns/1ps
module irq_hold_stage #(
  parameter int PRIO_W = 4,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [PRIO_W-1:0] mask_o
);
  logic              irq_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      vec_q  <= '0;
      mask_q <= '0;
    end else if (irq_q) begin
      if (ack_i) irq_q <= 1'b0;
    end else if (hit_i) begin
      irq_q  <= 1'b1;
      vec_q  <= vec_i;
      mask_q <= mask_i;
    end
  end

  assign irq_o  = irq_q;
  assign vec_o  = vec_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int N_SRC    = 8,
  parameter int PRIO_W   = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int NMI_VEC  = 11,
  parameter int UBRK_VEC = 12,
  parameter int DBG_VEC  = 13,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_i,
  input  logic              ubrk_i,
  input  logic              dbg_i,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [PRIO_W-1:0] cpu_mask_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PRIO_W-1:0] wr_lvl_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [PRIO_W-1:0] new_mask_o
);
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic                         hit;
  logic [VEC_W-1:0]             win_vec;
  logic [PRIO_W-1:0]            win_mask;

  irq_prio_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_lvl_i (wr_lvl_i),
    .prio_o   (prio)
  );

  irq_prio_arb #(
    .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
    .NMI_VEC(NMI_VEC), .UBRK_VEC(UBRK_VEC), .DBG_VEC(DBG_VEC)
  ) u_arb (
    .nmi_i      (nmi_i),
    .ubrk_i     (ubrk_i),
    .dbg_i      (dbg_i),
    .req_i      (req_i),
    .prio_i     (prio),
    .cpu_mask_i (cpu_mask_i),
    .hit_o      (hit),
    .vec_o      (win_vec),
    .mask_o     (win_mask)
  );

  irq_hold_stage #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .hit_i  (hit),
    .vec_i  (win_vec),
    .mask_i (win_mask),
    .ack_i  (ack_i),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .mask_o (new_mask_o)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctrl_chk #(
  parameter int N_SRC   = 8,
  parameter int PRIO_W  = 4,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              nmi_i,
  input logic              ubrk_i,
  input logic              dbg_i,
  input logic [N_SRC-1:0]  req_i,
  input logic [PRIO_W-1:0] cpu_mask_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [PRIO_W-1:0] new_mask_o
);
  localparam logic [PRIO_W-1:0] MASK_MAX = '1;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_o); // R1

  AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && nmi_i) |=> (irq_o && vec_o == VEC_W'(NMI_VEC))); // R2

  AST_NMI_MASK: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_o) && vec_o == VEC_W'(NMI_VEC)) |-> new_mask_o == MASK_MAX); // R8

  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_o) && vec_o != VEC_W'(NMI_VEC)) |-> new_mask_o > $past(cpu_mask_i)); // R5

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o) && $stable(new_mask_o))); // R10

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (irq_o && ack_i) |=> !irq_o); // R10

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (!irq_o && !nmi_i && !ubrk_i && !dbg_i && req_i == '0) |=> !irq_o); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_SRC(N_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nmi_i      (nmi_i),
  .ubrk_i     (ubrk_i),
  .dbg_i      (dbg_i),
  .req_i      (req_i),
  .cpu_mask_i (cpu_mask_i),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .new_mask_o (new_mask_o)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nmi_i = 0, ubrk_i = 0, dbg_i = 0, wr_en_i = 0, ack_i = 0;
  logic [7:0] req_i = '0;
  logic [3:0] cpu_mask_i = '0, wr_lvl_i = '0;
  logic [2:0] wr_idx_i = '0;
  logic       irq_o;
  logic [7:0] vec_o;
  logic [3:0] new_mask_o;

  int n_chk = 0;
  int n_fail = 0;
  int prio_m [N];

  always #4 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .ubrk_i(ubrk_i), .dbg_i(dbg_i),
    .req_i(req_i), .cpu_mask_i(cpu_mask_i), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_lvl_i(wr_lvl_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .new_mask_o(new_mask_o)
  );

  // Expected {irq, vec, mask} from the requirements (R2, R3, R5-R9)
  function automatic logic [12:0] model_out(logic nmi, logic ub, logic dg,
                                            logic [7:0] rq, logic [3:0] m);
    int bl = -1;
    int bi = -1;
    int vec;
    for (int i = 0; i < N + 3; i++) begin
      int l;
      logic p;
      if (i == 0) begin l = 16; p = nmi; end
      else if (i == 1) begin l = 15; p = ub; end
      else if (i == 2) begin l = 15; p = dg; end
      else begin l = prio_m[i-3]; p = rq[i-3]; end
      if (p && (i == 0 || l > int'(m)) && l > bl) begin
        bl = l;
        bi = i;
      end
    end
    if (bi < 0) return 13'd0;
    vec = (bi == 0) ? 11 : (bi == 1) ? 12 : (bi == 2) ? 13 : 64 + bi - 3;
    return {1'b1, 8'(vec), 4'((bl > 15) ? 15 : bl)};
  endfunction

  task automatic chk(string tag, logic [12:0] exp);
    logic [12:0] got = {irq_o, vec_o, new_mask_o};
    n_chk++;
    if ((exp[12] && got != exp) || (!exp[12] && irq_o !== 1'b0)) begin
      n_fail++;
      $display("FAIL %s: got irq=%0b vec=%0d mask=%0d, expected irq=%0b vec=%0d mask=%0d",
               tag, got[12], got[11:4], got[3:0], exp[12], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic wr(int idx, int lvl);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = 3'(idx); wr_lvl_i = 4'(lvl);
    @(negedge clk);
    wr_en_i = 1'b0;
    prio_m[idx] = lvl;
  endtask

  task automatic run_vec(string tag, logic nmi, logic ub, logic dg,
                         logic [7:0] rq, logic [3:0] m);
    logic [12:0] exp;
    @(negedge clk);
    nmi_i = nmi; ubrk_i = ub; dbg_i = dg; req_i = rq; cpu_mask_i = m;
    exp = model_out(nmi, ub, dg, rq, m);
    @(negedge clk);
    chk(tag, exp);
    if (exp[12]) begin
      // R10: outputs frozen while unacknowledged, inputs scrambled
      nmi_i = 1'($urandom); ubrk_i = 1'($urandom); dbg_i = 1'($urandom);
      req_i = 8'($urandom); cpu_mask_i = 4'($urandom);
      @(negedge clk);
      chk("R10 hold", exp);
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      chk("R10 ack clears", 13'd0);
    end
    nmi_i = 0; ubrk_i = 0; dbg_i = 0; req_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) prio_m[i] = 0;
    req_i = 8'hFF; ubrk_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 13'd0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 level-0 sources after reset", 13'd0);
    req_i = '0;

    run_vec("R2 NMI with mask 15", 1, 0, 0, 8'h00, 4'd15);
    run_vec("R2 NMI beats all", 1, 1, 1, 8'hFF, 4'd0);
    run_vec("R3 user break mask 14", 0, 1, 0, 8'h00, 4'd14);
    run_vec("R3 user break mask 15 rejected", 0, 1, 0, 8'h00, 4'd15);
    run_vec("R3 debug mask 3", 0, 0, 1, 8'h00, 4'd3);
    run_vec("R7 user break over debug", 0, 1, 1, 8'h00, 4'd0);
    wr(3, 7);
    run_vec("R4 src3 level 7 mask 6", 0, 0, 0, 8'h08, 4'd6);
    run_vec("R5 src3 level 7 mask 7 rejected", 0, 0, 0, 8'h08, 4'd7);
    run_vec("R5 level 0 src0 mask 0 rejected", 0, 0, 0, 8'h01, 4'd0);
    wr(2, 9); wr(5, 9);
    run_vec("R7 src2 over src5 at level 9", 0, 0, 0, 8'h24, 4'd1);
    wr(1, 3); wr(6, 12);
    run_vec("R6 src6 level 12 over src1 level 3", 0, 0, 0, 8'h42, 4'd2);
    wr(7, 15);
    run_vec("R7 user break over src7 level 15", 0, 1, 0, 8'h80, 4'd0);
    run_vec("R8 R9 src7 level 15 alone", 0, 0, 0, 8'h80, 4'd14);

    for (int it = 0; it < 400; it++) begin
      if ($urandom % 4 == 0) wr(int'($urandom % N), int'($urandom % 16));
      run_vec("R6 R8 R9 random", ($urandom % 16) == 0, ($urandom % 8) == 0,
              ($urandom % 8) == 0, 8'($urandom), 4'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule